// File: doc/BRIEF.md
# Selectable Sampling Clock Generator

This block produces the encoder and decoder bit clocks of a delta-modulation voice codec from a 1.024 MHz reference clock. A two-bit mode input picks one of three internal bit rates or an external-clock mode. In the internal modes a free-running binary divider generates a square-wave data clock. The block drives that clock out on both data clock pins, with the output enables asserted, so that circuits outside can lock to it. In external mode both pins are released to become inputs. Each injected clock is brought into the reference domain and edge-detected separately.

Every rising data clock edge, whether generated or injected, produces a strobe one reference cycle wide on the matching sampling enable output. The codec core uses these enables as its bit timing. A power-save input stops the divider and silences both enables. All control pins are plain levels and the enables are single-cycle pulses. There is no stream handshake, so no back-pressure applies.

Top module: `smpclk_gen`

## Requirements
- R1: While rst_n is low, enc_stb, dec_stb, enc_clk_out and dec_clk_out are all 0.
- R2: mode_sel codes 00, 01 and 10 select reference divide ratios of 16, 32 and 64 (64, 32 and 16 kbit/s from 1.024 MHz). In each of these modes a strobe occurs exactly once every ratio cycles.
- R3: The generated clock has a 50% duty cycle: low for the first half and high for the second half of each period, counted from a divider restart. Each strobe lasts one reference cycle and coincides with the first high cycle of the generated clock.
- R4: In codes 00, 01 and 10, enc_clk_oe and dec_clk_oe are 1, and both clock outputs carry the generated clock. enc_stb equals dec_stb, and enc_clk_in and dec_clk_in have no effect on any output.
- R5: In code 11, enc_clk_oe and dec_clk_oe are 0, and enc_clk_out and dec_clk_out are held at 0.
- R6: In code 11, each injected clock passes through two synchronising flip-flops. A rise on the pin produces a one-cycle strobe on its own enable in the second cycle after the first clock edge that samples the pin high. The encoder and decoder channels are independent, and any injected period of 16 to 128 reference cycles (64 down to 8 kbit/s) is followed.
- R7: While sleep is 1, the divider is held at zero and no strobe appears on either enable, even if the injected clocks toggle. Both clock outputs stay at 0. After sleep falls, the divider counts from zero: the first strobe comes in the cycle after the (ratio/2)-th clock edge with sleep low.
- R8: A change of mode_sel restarts the divider. The clock edge that samples the new code clears it, and the first strobe of the new rate comes ratio/2 edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.024 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Clock mode: 00/01/10 internal rate, 11 external |
| sleep | input | 1 | Power save, active high |
| enc_clk_in | input | 1 | Injected encoder data clock (pin input side) |
| dec_clk_in | input | 1 | Injected decoder data clock (pin input side) |
| enc_clk_out | output | 1 | Generated encoder data clock (pin output side) |
| dec_clk_out | output | 1 | Generated decoder data clock (pin output side) |
| enc_clk_oe | output | 1 | Drive enable for the encoder data clock pin |
| dec_clk_oe | output | 1 | Drive enable for the decoder data clock pin |
| enc_stb | output | 1 | One-cycle encoder sampling enable |
| dec_stb | output | 1 | One-cycle decoder sampling enable |

## Verification
A divider count that is off by one, or a wrong tap, shows up within one data period, at most 64 reference cycles, as a strobe or clock edge on the wrong cycle. The bench therefore predicts every cycle's strobe and clock level from the cycles elapsed since the last restart. A synchroniser with the wrong depth moves the external strobe by a cycle and is caught on the first injected edge. A sleep or mode-change path that fails to clear the divider leaves a phase error that the next strobe exposes.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;

  typedef enum logic [1:0] {
    MODE_DIV_LO  = 2'b00,
    MODE_DIV_MID = 2'b01,
    MODE_DIV_HI  = 2'b10,
    MODE_EXT     = 2'b11
  } clk_mode_e;

  localparam int unsigned NUM_RATES = 3;
  localparam int unsigned NUM_CHAN  = 2;

endpackage

// File: rtl/smpclk_div.sv
module smpclk_div #(
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned NRATE    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] rate_sel,
  output logic       gen_clk,
  output logic       gen_stb
);

  localparam int unsigned MAX_DIV = BASE_DIV << (NRATE - 1);
  localparam int unsigned CW      = $clog2(MAX_DIV);
  localparam int unsigned TAP0    = $clog2(BASE_DIV) - 1;

  logic [CW-1:0]    cnt;
  logic [NRATE-1:0] rate_clk;
  logic [NRATE-1:0] rate_stb;

  // power-of-two divider shared by every rate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // one tap per rate: bit TAP gives a clock of period 2^(TAP+1)
  for (genvar r = 0; r < NRATE; r++) begin : g_rate
    localparam int unsigned TAP = TAP0 + r;
    localparam logic [TAP:0] RISE_PAT = (TAP + 1)'(1) << TAP;
    assign rate_clk[r] = cnt[TAP];
    assign rate_stb[r] = (cnt[TAP:0] == RISE_PAT);
  end

  always_comb begin
    gen_clk = 1'b0;
    gen_stb = 1'b0;
    for (int r = 0; r < NRATE; r++) begin
      if (rate_sel == 2'(r)) begin
        gen_clk = rate_clk[r];
        gen_stb = rate_stb[r];
      end
    end
  end

  // R3: a strobe only in the first high cycle of the generated clock
  a_r3_stb_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    gen_stb |-> (gen_clk && !$past(gen_clk)));

  // R8: a clear leaves no strobe in the following cycle
  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> !gen_stb);

endmodule

// File: rtl/smpclk_edge.sv
module smpclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic pin,
  output logic stb
);

  logic meta_q;
  logic sync_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else if (clear) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign stb = sync_q & ~last_q;

  // R6: an external strobe lasts exactly one cycle
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

endmodule

// File: rtl/smpclk_gen.sv
module smpclk_gen #(
  parameter int unsigned BASE_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       sleep,
  input  logic       enc_clk_in,
  input  logic       dec_clk_in,
  output logic       enc_clk_out,
  output logic       dec_clk_out,
  output logic       enc_clk_oe,
  output logic       dec_clk_oe,
  output logic       enc_stb,
  output logic       dec_stb
);

  import smpclk_pkg::*;

  clk_mode_e mode_q;
  logic      ext_mode;
  logic      mode_chg;
  logic      div_clear;
  logic      ext_clear;
  logic      gen_clk;
  logic      gen_stb;
  logic [NUM_CHAN-1:0] pin_in;
  logic [NUM_CHAN-1:0] ext_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DIV_LO;
    else        mode_q <= clk_mode_e'(mode_sel);
  end

  assign ext_mode  = (mode_q == MODE_EXT);
  assign mode_chg  = (clk_mode_e'(mode_sel) != mode_q);
  assign div_clear = sleep | mode_chg | ext_mode;
  assign ext_clear = sleep | ~ext_mode;

  smpclk_div #(
    .BASE_DIV (BASE_DIV),
    .NRATE    (NUM_RATES)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (div_clear),
    .rate_sel (mode_q),
    .gen_clk  (gen_clk),
    .gen_stb  (gen_stb)
  );

  assign pin_in = {dec_clk_in, enc_clk_in};

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    smpclk_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ext_clear),
      .pin   (pin_in[c]),
      .stb   (ext_stb[c])
    );
  end

  assign enc_clk_oe  = ~ext_mode;
  assign dec_clk_oe  = ~ext_mode;
  assign enc_clk_out = ext_mode ? 1'b0 : gen_clk;
  assign dec_clk_out = ext_mode ? 1'b0 : gen_clk;
  assign enc_stb     = ext_mode ? ext_stb[0] : gen_stb;
  assign dec_stb     = ext_mode ? ext_stb[1] : gen_stb;

  // R5: a released pin is never driven high
  a_r5_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_clk_oe |-> (!enc_clk_out && !dec_clk_out));

  // R7: no strobe in the cycle after sleep was sampled
  a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> (!enc_stb && !dec_stb));

  // R4: internal clocking gives both channels the same strobe
  a_r4_common_stb: assert property (@(posedge clk) disable iff (!rst_n)
    enc_clk_oe |-> (enc_stb == dec_stb));

endmodule

// File: tb/smpclk_gen_test.sv
module smpclk_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       sleep = 1'b0;
  logic       enc_clk_in = 1'b0;
  logic       dec_clk_in = 1'b0;
  logic       enc_clk_out, dec_clk_out, enc_clk_oe, dec_clk_oe, enc_stb, dec_stb;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smpclk_gen #(.BASE_DIV(16)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep(sleep),
    .enc_clk_in(enc_clk_in), .dec_clk_in(dec_clk_in),
    .enc_clk_out(enc_clk_out), .dec_clk_out(dec_clk_out),
    .enc_clk_oe(enc_clk_oe), .dec_clk_oe(dec_clk_oe),
    .enc_stb(enc_stb), .dec_stb(dec_stb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // internal rate: m counts divider value since restart
  task automatic check_int(input string req, input int d, input int m);
    int ph = m % d;
    chk(req, "enc_stb", int'(enc_stb), int'(ph == d / 2));
    chk(req, "dec_stb", int'(dec_stb), int'(ph == d / 2));
    chk(req, "enc_clk_out", int'(enc_clk_out), int'(ph >= d / 2));
    chk(req, "dec_clk_out", int'(dec_clk_out), int'(ph >= d / 2));
    chk("R4", "oe", int'({enc_clk_oe, dec_clk_oe}), 3);
  endtask

  // mode change applied at the next edge; m=0 at the following negedge (R8)
  task automatic run_int(input string req, input logic [1:0] code, input int d,
                         input int n, input bit toggle);
    @(negedge clk);
    mode_sel = code;
    for (int m = 0; m < n; m++) begin
      @(negedge clk);
      check_int(req, d, m);
      if (toggle) begin
        enc_clk_in = m[1];
        dec_clk_in = m[2] ^ m[0];
      end
    end
    enc_clk_in = 1'b0;
    dec_clk_in = 1'b0;
  endtask

  task automatic run_ext(input int pe, input int pd, input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk("R6", "enc_stb", int'(enc_stb), int'((i - 2) >= pe && ((i - 2) % pe) == 0));
      chk("R6", "dec_stb", int'(dec_stb), int'((i - 2) >= pd && ((i - 2) % pd) == 0));
      chk("R5", "pins", int'({enc_clk_oe, dec_clk_oe, enc_clk_out, dec_clk_out}), 0);
      enc_clk_in = (i >= pe) && ((i % pe) < pe / 2);
      dec_clk_in = (i >= pd) && ((i % pd) < pd / 2);
    end
    enc_clk_in = 1'b0;
    dec_clk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs in reset", int'({enc_stb, dec_stb, enc_clk_out, dec_clk_out}), 0);
    rst_n = 1'b1;

    run_int("R2", 2'b01, 32, 200, 1'b0);
    run_int("R2", 2'b10, 64, 300, 1'b0);
    run_int("R3", 2'b00, 16, 100, 1'b0);
    // R4: injected clocks toggle while internal mode must ignore them
    run_int("R4", 2'b10, 64, 200, 1'b1);
    run_int("R8", 2'b01, 32, 40, 1'b1);
    run_int("R8", 2'b00, 16, 60, 1'b0);

    // external mode
    @(negedge clk);
    mode_sel = 2'b11;
    repeat (4) begin
      @(negedge clk);
      chk("R5", "oe after switch", int'({enc_clk_oe, dec_clk_oe}), 0);
      chk("R6", "quiet stb", int'({enc_stb, dec_stb}), 0);
    end
    run_ext(16, 128, 400);
    run_ext(40, 22, 300);
    run_ext(128, 16, 400);
    run_ext(17, 95, 300);

    // R7: sleep in external mode with toggling pins
    @(negedge clk);
    sleep = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chk("R7", "ext sleep stb", int'({enc_stb, dec_stb}), 0);
      enc_clk_in = i[2];
      dec_clk_in = i[1];
    end
    enc_clk_in = 1'b0;
    dec_clk_in = 1'b0;
    mode_sel = 2'b01;
    // R7: sleep in internal mode
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      chk("R7", "int sleep", int'({enc_stb, dec_stb, enc_clk_out, dec_clk_out}), 0);
    end
    sleep = 1'b0;
    for (int m = 1; m < 130; m++) begin
      @(negedge clk);
      check_int("R7", 32, m);
    end

    // sleep again at the fastest rate
    run_int("R2", 2'b00, 16, 50, 1'b0);
    @(negedge clk);
    sleep = 1'b1;
    repeat (10) @(negedge clk);
    sleep = 1'b0;
    for (int m = 1; m < 70; m++) begin
      @(negedge clk);
      check_int("R7", 16, m);
    end

    // R1: reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "outputs in reset", int'({enc_stb, dec_stb, enc_clk_out, dec_clk_out}), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule